// File: doc/BRIEF.md
# Field-Aware Pixel-Precise Vertical Sync Generator

This block drives the vertical sync line of an interlaced display. An external timing chain supplies the current frame line count, the current pixel count within that line, and a flag naming the field being scanned. The block holds four coordinate registers: a start point and a stop point for field 1, and another start/stop pair for field 2. Each cycle it compares the counters against the pair chosen by the field flag. A start hit raises the sync output and a stop hit lowers it, so both edges land on an exact pixel rather than on a line boundary.

Software programs the coordinates through a small word-addressed port. Each register packs a line coordinate in the upper half-word and a pixel coordinate in the lower half-word. The upper four bits of each half-word are unused. The sync output is registered: it reflects a match one clock after the counters show it, and it keeps its level between matches.

Top module: `vsync_gen`

## Requirements
- R1: When the counters equal the start coordinates of the selected field and do not equal its stop coordinates, vsync_o is 1 after the next rising clock edge.
- R2: When the counters equal the stop coordinates of the selected field, vsync_o is 0 after the next rising clock edge.
- R3: When neither the start nor the stop coordinates of the selected field match, vsync_o keeps its level across the clock edge.
- R4: field_i = 0 selects the field-1 pair (addresses 0 and 1). field_i = 1 selects the field-2 pair (addresses 2 and 3). Coordinates of the unselected field have no effect on vsync_o.
- R5: Address 0 holds the field-1 start, 1 the field-1 stop, 2 the field-2 start and 3 the field-2 stop. A write stores wdata bits 27:16 as the line and bits 11:0 as the pixel. reg_rdata_o shows the addressed register in the same cycle, with the same bit layout.
- R6: Bits 31:28 and 15:12 of reg_rdata_o always read 0. Values written to those bits have no effect.
- R7: When start and stop coordinates are identical, a match drives vsync_o to 0 (stop wins).
- R8: While rst_ni is low, all coordinate registers read 0 and vsync_o is 0.
- R9: A register write is used for comparison from the clock after the write edge. In the write cycle, the comparison uses the old value.
- R10: Coordinate 0xFFF is stored in full and matches counter value 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| line_cnt_i | input | 12 | Frame line count |
| pix_cnt_i | input | 12 | Pixel count within the line |
| field_i | input | 1 | Field flag: 0 = field 1, 1 = field 2 |
| vsync_o | output | 1 | Registered vertical sync |

## Verification
A start match and a stop match can occur in the same cycle when a field's two registers hold the same coordinates. The bench provokes this by programming field 1 with equal start and stop points while vsync_o is already high from a field-2 start. It then presents those coordinates with field_i = 0 and expects vsync_o to fall. A register write can also coincide with a counter value that equals the newly written data. The bench expects no edge in that cycle and an edge one cycle later.

// File: rtl/vsync_gen_pkg.sv
package vsync_gen_pkg;
  typedef enum logic [1:0] {
    REG_START_F1 = 2'd0,
    REG_STOP_F1  = 2'd1,
    REG_START_F2 = 2'd2,
    REG_STOP_F2  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_FIELDS     = 2;
  localparam int unsigned REGS_PER_FIELD = 2;
  localparam int unsigned NUM_REGS       = NUM_FIELDS * REGS_PER_FIELD;
  localparam int unsigned LINE_LSB       = 16;
  localparam int unsigned PIX_LSB        = 0;
endpackage

// File: rtl/vsync_gen_regs.sv
module vsync_gen_regs
  import vsync_gen_pkg::*;
#(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [COORD_W-1:0] line_o [NUM_REGS],
  output logic [COORD_W-1:0] pix_o  [NUM_REGS]
);
  localparam int unsigned LINE_MSB = LINE_LSB + COORD_W;
  localparam int unsigned PIX_MSB  = PIX_LSB + COORD_W;

  logic [COORD_W-1:0] line_q [NUM_REGS];
  logic [COORD_W-1:0] pix_q  [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q[g] <= '0;
        pix_q[g]  <= '0;
      end else if (we_i && (addr_i == ADDR_W'(g))) begin
        line_q[g] <= wdata_i[LINE_LSB +: COORD_W];
        pix_q[g]  <= wdata_i[PIX_LSB +: COORD_W];
      end
    end
    assign line_o[g] = line_q[g];
    assign pix_o[g]  = pix_q[g];
  end

  // gap bits between fields are never stored
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:LINE_MSB], wdata_i[LINE_LSB-1:PIX_MSB]};

  always_comb begin
    rdata_o = '0;
    rdata_o[LINE_LSB +: COORD_W] = line_q[addr_i];
    rdata_o[PIX_LSB +: COORD_W]  = pix_q[addr_i];
  end
endmodule

// File: rtl/vsync_gen_match.sv
module vsync_gen_match
  import vsync_gen_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic [COORD_W-1:0] line_i,
  input  logic [COORD_W-1:0] pix_i,
  input  logic               field_i,
  input  logic [COORD_W-1:0] reg_line_i [NUM_REGS],
  input  logic [COORD_W-1:0] reg_pix_i  [NUM_REGS],
  output logic               start_hit_o,
  output logic               stop_hit_o
);
  logic [NUM_FIELDS-1:0] start_f;
  logic [NUM_FIELDS-1:0] stop_f;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int unsigned START_IDX = f * REGS_PER_FIELD;
    localparam int unsigned STOP_IDX  = START_IDX + 1;
    assign start_f[f] = (line_i == reg_line_i[START_IDX]) && (pix_i == reg_pix_i[START_IDX]);
    assign stop_f[f]  = (line_i == reg_line_i[STOP_IDX])  && (pix_i == reg_pix_i[STOP_IDX]);
  end

  assign start_hit_o = start_f[field_i];
  assign stop_hit_o  = stop_f[field_i];
endmodule

// File: rtl/vsync_gen_out.sv
module vsync_gen_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_hit_i,
  input  logic stop_hit_i,
  output logic vsync_o
);
  logic vsync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vsync_q <= 1'b0;
    else if (stop_hit_i)  vsync_q <= 1'b0;  // stop wins on a tie
    else if (start_hit_i) vsync_q <= 1'b1;
  end

  assign vsync_o = vsync_q;
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen
  import vsync_gen_pkg::*;
#(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [COORD_W-1:0] line_cnt_i,
  input  logic [COORD_W-1:0] pix_cnt_i,
  input  logic               field_i,
  output logic               vsync_o
);
  logic [COORD_W-1:0] reg_line [NUM_REGS];
  logic [COORD_W-1:0] reg_pix  [NUM_REGS];
  logic               start_hit;
  logic               stop_hit;

  vsync_gen_regs #(
    .COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .line_o  (reg_line),
    .pix_o   (reg_pix)
  );

  vsync_gen_match #(.COORD_W(COORD_W)) u_match (
    .line_i      (line_cnt_i),
    .pix_i       (pix_cnt_i),
    .field_i     (field_i),
    .reg_line_i  (reg_line),
    .reg_pix_i   (reg_pix),
    .start_hit_o (start_hit),
    .stop_hit_o  (stop_hit)
  );

  vsync_gen_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_hit_i (start_hit),
    .stop_hit_i  (stop_hit),
    .vsync_o     (vsync_o)
  );
endmodule

// File: rtl/vsync_gen_chk.sv
module vsync_gen_chk #(
  parameter int unsigned COORD_W = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic [COORD_W-1:0] line_cnt_i,
  input logic [COORD_W-1:0] pix_cnt_i,
  input logic               field_i,
  input logic               vsync_o
);
  localparam int unsigned NREG = 4;

  logic [DATA_W-1:0] shadow [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow[g] <= '0;
      else if (reg_we_i && (reg_addr_i == ADDR_W'(g))) shadow[g] <= reg_wdata_i & 32'h0FFF_0FFF;
    end
  end

  logic [DATA_W-1:0] cnt_word;
  logic [1:0]        base;
  logic              start_m;
  logic              stop_m;

  assign cnt_word = {4'h0, line_cnt_i, 4'h0, pix_cnt_i};
  assign base     = field_i ? 2'd2 : 2'd0;
  assign start_m  = (shadow[base] == cnt_word);
  assign stop_m   = (shadow[base + 2'd1] == cnt_word);

  // R1
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_m && !stop_m |=> vsync_o);

  // R2
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_m |=> !vsync_o);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_m && !stop_m |=> $stable(vsync_o));

  // R5
  rdback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o == shadow[reg_addr_i]);

  // R6
  rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:28] == 4'h0 && reg_rdata_o[15:12] == 4'h0);
endmodule

bind vsync_gen vsync_gen_chk #(.COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vsync_gen_tb.sv
module vsync_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [11:0] line_cnt_i = '0;
  logic [11:0] pix_cnt_i = '0;
  logic        field_i = 1'b0;
  logic        vsync_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  vsync_gen u_dut (.*);

  // {line, pix, field, expected vsync after edge}
  localparam logic [25:0] VEC [10] = '{
    {12'd0,   12'd0,     1'b0, 1'b0},
    {12'd10,  12'd20,    1'b1, 1'b0},  // R4 field-1 start ignored on field 2
    {12'd10,  12'd20,    1'b0, 1'b1},  // R1
    {12'd11,  12'd0,     1'b0, 1'b1},  // R3
    {12'd12,  12'd5,     1'b1, 1'b1},  // R4 field-1 stop ignored on field 2
    {12'd12,  12'd5,     1'b0, 1'b0},  // R2
    {12'd300, 12'h7FF,   1'b0, 1'b0},  // R4 field-2 start ignored on field 1
    {12'd300, 12'h7FF,   1'b1, 1'b1},  // R1 field 2
    {12'd12,  12'd5,     1'b1, 1'b1},  // R4
    {12'hFFF, 12'hFFF,   1'b1, 1'b0}   // R10 stop at max coordinate
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic step(input logic [11:0] l, input logic [11:0] p, input logic f);
    line_cnt_i = l; pix_cnt_i = p; field_i = f;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    line_cnt_i = 12'd4000; pix_cnt_i = 12'd4000;
    repeat (2) @(negedge clk_i);
    // R8 reset state
    chk("R8 vsync", {31'd0, vsync_o}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a); #1;
      chk("R8 reg", reg_rdata_o, 32'd0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 map and read back, R6 reserved bits dropped
    wr(2'd0, 32'hF00A_F014);
    wr(2'd1, 32'h000C_0005);
    wr(2'd2, 32'h012C_07FF);
    wr(2'd3, 32'hFFFF_FFFF);
    reg_addr_i = 2'd0; #1; chk("R6 start f1", reg_rdata_o, 32'h000A_0014);
    reg_addr_i = 2'd1; #1; chk("R5 stop f1",  reg_rdata_o, 32'h000C_0005);
    reg_addr_i = 2'd2; #1; chk("R5 start f2", reg_rdata_o, 32'h012C_07FF);
    reg_addr_i = 2'd3; #1; chk("R10 stop f2", reg_rdata_o, 32'h0FFF_0FFF);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][25:14], VEC[i][13:2], VEC[i][1]);
      chk($sformatf("R1-4 vec%0d", i), {31'd0, vsync_o}, {31'd0, VEC[i][0]});
    end

    // R7 equal start/stop: vsync high from field 2, tie on field 1 lowers it
    wr(2'd0, 32'h0005_0005);
    wr(2'd1, 32'h0005_0005);
    step(12'd300, 12'h7FF, 1'b1);
    chk("R1 preset", {31'd0, vsync_o}, 32'd1);
    step(12'd5, 12'd5, 1'b0);
    chk("R7 tie", {31'd0, vsync_o}, 32'd0);
    step(12'd5, 12'd5, 1'b0);
    chk("R7 tie stays low", {31'd0, vsync_o}, 32'd0);

    // R9 write coincides with matching counters
    line_cnt_i = 12'd7; pix_cnt_i = 12'd7; field_i = 1'b0;
    wr(2'd0, 32'h0007_0007);
    chk("R9 write cycle", {31'd0, vsync_o}, 32'd0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R9 next cycle", {31'd0, vsync_o}, 32'd1);

    // R10 start at max coordinate on field 2
    wr(2'd2, 32'h0FFF_0FFE);
    step(12'd1, 12'd1, 1'b0);
    step(12'hFFF, 12'hFFE, 1'b1);
    chk("R10 start max", {31'd0, vsync_o}, 32'd1);

    // R8 reset mid-run
    rst_ni = 1'b0; #1;
    chk("R8 vsync mid", {31'd0, vsync_o}, 32'd0);
    reg_addr_i = 2'd2; #1;
    chk("R8 reg mid", reg_rdata_o, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule